// File: doc/BRIEF.md
# Multi-pixel histogram and CDF builder

This block counts how often each 8-bit grey level occurs in a frame of pixels that arrives several pixels per clock. When the frame is complete it walks the grey levels from 0 upward, turns the counts into a cumulative distribution, and records the first non-zero cumulative value. These are the inputs a histogram-equalisation remapper needs. The frame length is a parameter. The remapping itself and the fetching of pixels from memory belong to other blocks.

A frame begins with a one-cycle `sof` pulse. The block then spends 256 cycles zeroing its counters, with `in_ready` low. Next it accepts exactly `FRAME_PIXELS/LANES` beats on a valid/ready bus. Each lane keeps its own bank of counters. Within one beat, lanes that carry the same grey level are folded into a single increment in the lowest such lane. A write to a bin that is still in flight is forwarded to the next beat that reads the same bin. After the last beat a 256-step scan sums the banks, writes each cumulative value into a result memory that can be read at any time, captures the minimum non-zero value, and pulses `done`.

Top module: `hcb_hist_cdf`

## Requirements
- R1: While `rst` is high and after it is released, `in_ready`, `done` and `cdf_min` are all 0 until a frame is started.
- R2: A cycle with `sof` high starts a counter clear. `in_ready` is low in the cycle after `sof` and first reads high 256 clock edges after the edge that sampled `sof`.
- R3: A beat is accepted on an edge where `in_valid` and `in_ready` are high and `sof` is low. Lane i occupies `in_pix[8*i+7:8*i]`, lane 0 in the least significant byte, and every lane of an accepted beat adds one count to its grey level.
- R4: Lanes of one beat that carry the same grey level are all counted, so a beat of four equal pixels adds 4 to that bin.
- R5: Accepted beats on consecutive edges that hit the same bin are all counted, with no increment lost.
- R6: After `FRAME_PIXELS/LANES` beats have been accepted, `in_ready` is low from the next cycle on. Pixels presented afterwards change neither the counts nor the results.
- R7: After `done`, reading address v on `rd_addr` gives, on `rd_data` one cycle later, the total count of grey levels 0 through v in the frame.
- R8: After `done`, `cdf_min` equals the cumulative value at the lowest grey level whose cumulative value is non-zero. This is the count of the darkest grey level present.
- R9: `done` is high for exactly one cycle, 258 clock edges after the edge that accepted the last beat of the frame.
- R10: `cdf_min` and the result memory hold their values from `done` until the next `sof`. `cdf_min` reads 0 from the edge that samples `sof` until the next scan sets it.
- R11: A `sof` during counting abandons the partial frame. Its pixels, and any beat offered in the same cycle as `sof`, do not appear in the next frame's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse, clears the counters |
| in_valid | input | 1 | Pixel beat valid |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_pix | input | LANES*8 | Pixels of one beat, lane 0 in the low byte |
| rd_addr | input | 8 | Grey level whose cumulative value is read |
| rd_data | output | CNT_W | Cumulative value at `rd_addr`, one cycle after |
| cdf_min | output | CNT_W | First non-zero cumulative value of the last frame |
| done | output | 1 | One-cycle pulse when the scan finishes |

## Verification
Two functions can fall in the same cycle. One is the read of a bin for a new beat; the other is the write-back of the previous beat's increment to that same bin. The in-beat fold of equal lanes can also stack on top of the read and write-back. Frames made of identical pixels and of alternating beats of repeated grey levels provoke this on every edge. A frame that restarts while a beat is valid does the same for the case where `sof` and a beat coincide. Each case is judged by comparing all 256 read-back cumulative values, and `cdf_min`, with totals the bench accumulates from the pixels it actually had accepted. A single lost or doubled increment therefore shows at that bin and at every bin above it.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COUNT,
    ST_FLUSH,
    ST_SCAN,
    ST_FIN
  } hcb_state_e;

endpackage

// File: rtl/hcb_lane_merge.sv
// Folds lanes of one beat that carry the same grey level into the
// lowest such lane; later duplicates are marked as non-leading.
module hcb_lane_merge #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int INC_W = 3
) (
  input  logic [LANES*PIX_W-1:0] pix,
  output logic [LANES-1:0]       lead,
  output logic [LANES*INC_W-1:0] inc
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic             dup;
    logic [INC_W-1:0] cnt;

    always_comb begin
      dup = 1'b0;
      cnt = '0;
      for (int j = 0; j < LANES; j++) begin
        if (pix[j*PIX_W +: PIX_W] == pix[i*PIX_W +: PIX_W]) begin
          if (j < i) dup = 1'b1;
          else       cnt = cnt + INC_W'(1);
        end
      end
    end

    assign lead[i]              = ~dup;
    assign inc[i*INC_W +: INC_W] = cnt;
  end

endmodule

// File: rtl/hcb_bin_bank.sv
// One bank of bin counters: read-first block RAM with a one-deep
// forwarding register covering back-to-back updates of one bin.
module hcb_bin_bank #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 24,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [PIX_W-1:0] clr_addr,
  input  logic             acc_en,
  input  logic [PIX_W-1:0] acc_bin,
  input  logic [INC_W-1:0] acc_inc,
  input  logic             scan_en,
  input  logic [PIX_W-1:0] scan_addr,
  output logic [CNT_W-1:0] rd_q
);

  localparam int DEPTH = 1 << PIX_W;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [PIX_W-1:0] raddr;

  logic             s1_vld;
  logic [PIX_W-1:0] s1_bin;
  logic [INC_W-1:0] s1_inc;
  logic             fw_vld;
  logic [PIX_W-1:0] fw_bin;
  logic [CNT_W-1:0] fw_val;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] upd;

  assign raddr = scan_en ? scan_addr : acc_bin;

  always_comb begin
    base = (fw_vld && (fw_bin == s1_bin)) ? fw_val : rd_q;
    upd  = base + CNT_W'(s1_inc);
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[raddr];
    if (clr_en)      mem[clr_addr] <= '0;
    else if (s1_vld) mem[s1_bin]   <= upd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      fw_vld <= 1'b0;
    end else begin
      s1_vld <= acc_en & ~clr_en;
      fw_vld <= s1_vld & ~clr_en;
    end
    s1_bin <= acc_bin;
    s1_inc <= acc_inc;
    fw_bin <= s1_bin;
    fw_val <= upd;
  end

endmodule

// File: rtl/hcb_cdf_store.sv
// Result memory: one write port from the scan, one registered read port.
module hcb_cdf_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [1 << ADDR_W];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hcb_hist_cdf.sv
module hcb_hist_cdf
  import hcb_pkg::*;
#(
  parameter int LANES        = 4,
  parameter int PIX_W        = 8,
  parameter int CNT_W        = 24,
  parameter int FRAME_PIXELS = 262144
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sof,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_pix,
  input  logic [PIX_W-1:0]       rd_addr,
  output logic [CNT_W-1:0]       rd_data,
  output logic [CNT_W-1:0]       cdf_min,
  output logic                   done
);

  localparam int INC_W       = $clog2(LANES + 1);
  localparam int FRAME_BEATS = FRAME_PIXELS / LANES;
  localparam int BEAT_W      = $clog2(FRAME_BEATS + 1);

  hcb_state_e       state;
  logic [PIX_W-1:0] idx;
  logic [BEAT_W-1:0] beat_cnt;
  logic             acc;

  logic [LANES-1:0]       lead;
  logic [LANES*INC_W-1:0] inc;
  logic [CNT_W-1:0]       bank_q [LANES];

  logic             p_vld;
  logic [PIX_W-1:0] p_bin;
  logic [CNT_W-1:0] run_sum;
  logic [CNT_W-1:0] bin_total;
  logic [CNT_W-1:0] cdf_next;
  logic             min_found;

  assign acc = in_valid & in_ready & ~sof;

  // Frame sequencing: clear sweep, counting, flush, scan, finish.
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      beat_cnt <= '0;
      in_ready <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sof) begin
        state    <= ST_CLEAR;
        idx      <= '0;
        in_ready <= 1'b0;
      end else begin
        case (state)
          ST_CLEAR: begin
            idx <= idx + 1'b1;
            if (idx == '1) begin
              state    <= ST_COUNT;
              in_ready <= 1'b1;
              beat_cnt <= '0;
            end
          end
          ST_COUNT: begin
            if (acc) begin
              beat_cnt <= beat_cnt + 1'b1;
              if (beat_cnt == BEAT_W'(FRAME_BEATS - 1)) begin
                state    <= ST_FLUSH;
                in_ready <= 1'b0;
              end
            end
          end
          ST_FLUSH: begin
            state <= ST_SCAN;
            idx   <= '0;
          end
          ST_SCAN: begin
            idx <= idx + 1'b1;
            if (idx == '1) state <= ST_FIN;
          end
          ST_FIN: begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  hcb_lane_merge #(
    .LANES (LANES),
    .PIX_W (PIX_W),
    .INC_W (INC_W)
  ) u_merge (
    .pix  (in_pix),
    .lead (lead),
    .inc  (inc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    hcb_bin_bank #(
      .PIX_W (PIX_W),
      .CNT_W (CNT_W),
      .INC_W (INC_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .clr_en    (state == ST_CLEAR),
      .clr_addr  (idx),
      .acc_en    (acc & lead[g]),
      .acc_bin   (in_pix[g*PIX_W +: PIX_W]),
      .acc_inc   (inc[g*INC_W +: INC_W]),
      .scan_en   (state == ST_SCAN),
      .scan_addr (idx),
      .rd_q      (bank_q[g])
    );
  end

  always_comb begin
    bin_total = '0;
    for (int k = 0; k < LANES; k++) bin_total = bin_total + bank_q[k];
    cdf_next = run_sum + bin_total;
  end

  // Prefix-sum pass and capture of the first non-zero cumulative value.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_vld     <= 1'b0;
      run_sum   <= '0;
      min_found <= 1'b0;
      cdf_min   <= '0;
    end else begin
      p_vld <= (state == ST_SCAN) & ~sof;
      if (sof) begin
        run_sum   <= '0;
        min_found <= 1'b0;
        cdf_min   <= '0;
      end else if (p_vld) begin
        run_sum <= cdf_next;
        if (!min_found && (cdf_next != '0)) begin
          cdf_min   <= cdf_next;
          min_found <= 1'b1;
        end
      end
    end
    p_bin <= idx;
  end

  hcb_cdf_store #(
    .ADDR_W (PIX_W),
    .DATA_W (CNT_W)
  ) u_store (
    .clk   (clk),
    .we    (p_vld & ~sof),
    .waddr (p_bin),
    .wdata (cdf_next),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/hcb_hist_cdf_chk.sv
module hcb_hist_cdf_chk #(
  parameter int CNT_W       = 24,
  parameter int FRAME_BEATS = 65536
) (
  input logic             clk,
  input logic             rst,
  input logic             sof,
  input logic             in_valid,
  input logic             in_ready,
  input logic             done,
  input logic [CNT_W-1:0] cdf_min
);

  logic [31:0] seen_beats;
  logic        held;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_beats <= '0;
      held       <= 1'b0;
    end else begin
      if (sof)                       seen_beats <= '0;
      else if (in_valid && in_ready) seen_beats <= seen_beats + 1'b1;
      if (sof)       held <= 1'b0;
      else if (done) held <= 1'b1;
    end
  end

  // R2: a frame start closes the input during the clear sweep
  a_r2_ready_low_after_sof: assert property (@(posedge clk) disable iff (rst)
    sof |=> !in_ready);

  // R6: the beat that completes the frame closes the input
  a_r6_frame_len: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !sof && seen_beats == 32'(FRAME_BEATS - 1)) |=> !in_ready);

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: completion never overlaps pixel acceptance
  a_r9_done_not_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  // R10: minimum value holds between completion and the next frame start
  a_r10_min_hold: assert property (@(posedge clk) disable iff (rst)
    (held && !sof) |=> $stable(cdf_min));

endmodule

bind hcb_hist_cdf hcb_hist_cdf_chk #(
  .CNT_W       (CNT_W),
  .FRAME_BEATS (FRAME_PIXELS / LANES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sof      (sof),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .cdf_min  (cdf_min)
);

// File: tb/tb_hcb_hist_cdf.sv
module tb_hcb_hist_cdf;

  localparam int LANES = 4;
  localparam int PIX_W = 8;
  localparam int CNT_W = 24;
  localparam int FRAME_PIXELS = 64;
  localparam int BEATS = FRAME_PIXELS / LANES;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   sof = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic [LANES*PIX_W-1:0] in_pix = '0;
  logic [PIX_W-1:0]       rd_addr = '0;
  logic [CNT_W-1:0]       rd_data;
  logic [CNT_W-1:0]       cdf_min;
  logic                   done;

  always #10 clk = ~clk;

  hcb_hist_cdf #(
    .LANES        (LANES),
    .PIX_W        (PIX_W),
    .CNT_W        (CNT_W),
    .FRAME_PIXELS (FRAME_PIXELS)
  ) dut (
    .clk      (clk),
    .rst      (rst),
    .sof      (sof),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_pix   (in_pix),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cdf_min  (cdf_min),
    .done     (done)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    exp_hist [256];
  int    exp_q [$];
  int    addr_q [$];
  logic  rd_req = 1'b0;
  logic  rd_req_d = 1'b0;
  string tag = "R7";

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares read-back values against queued expectations
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d) begin
      int e;
      int a;
      e = exp_q.pop_front();
      a = addr_q.pop_front();
      check($sformatf("%s R7 cdf[%0d]", tag, a), int'(rd_data), e);
    end
  end

  task automatic start_frame();
    int cnt;
    @(negedge clk) sof = 1'b1;
    @(posedge clk);
    @(negedge clk) sof = 1'b0;
    in_valid = 1'b0;
    check("R10 cdf_min cleared by sof", int'(cdf_min), 0);
    check("R2 ready low after sof", int'(in_ready), 0);
    foreach (exp_hist[i]) exp_hist[i] = 0;
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end while (!in_ready && cnt < 1000);
    check("R2 clear length", cnt, 256);
  endtask

  task automatic send_beat(input logic [31:0] px, input bit count_it);
    @(negedge clk);
    in_valid = 1'b1;
    in_pix   = px;
    @(posedge clk);
    if (count_it)
      for (int l = 0; l < LANES; l++) exp_hist[px[l*8 +: 8]]++;
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_pix   = 32'h0101_0101;
    end
  endtask

  task automatic finish_frame(input string t);
    int cnt;
    int run;
    int mn;
    logic [CNT_W-1:0] held_min;
    tag = t;
    cnt = 0;
    @(negedge clk);
    check({t, " R6 ready low after last beat"}, int'(in_ready), 0);
    // keep offering pixels after the frame: they must be ignored (R6)
    in_valid = 1'b1;
    in_pix   = 32'h0000_0000;
    while (!done && cnt < 1000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      in_pix = in_pix + 32'h0100_0001;
    end
    check({t, " R9 done latency"}, cnt, 258);
    @(negedge clk);
    in_valid = 1'b0;
    check({t, " R9 done one cycle"}, int'(done), 0);
    run = 0;
    mn  = 0;
    for (int v = 0; v < 256; v++) begin
      run += exp_hist[v];
      if (mn == 0 && run != 0) mn = run;
    end
    check({t, " R8 cdf_min"}, int'(cdf_min), mn);
    held_min = cdf_min;
    run = 0;
    for (int v = 0; v < 256; v++) begin
      run += exp_hist[v];
      @(negedge clk);
      rd_addr = 8'(v);
      rd_req  = 1'b1;
      exp_q.push_back(run);
      addr_q.push_back(v);
    end
    @(negedge clk) rd_req = 1'b0;
    repeat (3) @(negedge clk);
    check({t, " R10 cdf_min held"}, int'(cdf_min), int'(held_min));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready in reset", int'(in_ready), 0);
    check("R1 done in reset", int'(done), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 0);
    check("R1 cdf_min after reset", int'(cdf_min), 0);

    // Frame A: varied pixels with idle gaps (R3, R7, R8)
    start_frame();
    for (int b = 0; b < BEATS; b++) begin
      logic [31:0] px;
      for (int l = 0; l < LANES; l++) px[l*8 +: 8] = 8'(20 + $urandom_range(0, 39));
      send_beat(px, 1'b1);
      if (b % 3 == 2) gap(2);
    end
    finish_frame("R3 varied");

    // Frame B: every pixel the same level, back to back (R4, R5)
    start_frame();
    for (int b = 0; b < BEATS; b++) send_beat(32'hC8C8_C8C8, 1'b1);
    finish_frame("R4 R5 uniform");

    // Frame C: partial in-beat duplicates, alternating beats (R4, R5)
    start_frame();
    for (int b = 0; b < BEATS; b++) begin
      case (b % 3)
        0:       send_beat(32'h0509_0505, 1'b1);
        1:       send_beat(32'h0909_0909, 1'b1);
        default: send_beat(32'h0905_0905, 1'b1);
      endcase
    end
    finish_frame("R4 R5 mixed");

    // Frame D: abandoned partial frame, sof with a valid beat (R11)
    start_frame();
    for (int b = 0; b < 5; b++) send_beat(32'h0000_0000, 1'b0);
    start_frame();
    for (int b = 0; b < BEATS; b++) send_beat(32'hFF07_6407, 1'b1);
    finish_frame("R11 restart");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule